// File: doc/BRIEF.md
# Rotate Unit with Carry and Overflow Flags

This block rotates an 8, 16 or 32-bit operand left, right, or right through the carry flag. It then produces the new carry (CF) and overflow (OF) flags with the bit-exact behaviour of a legacy integer core, including the undocumented cases. OF is derived from the result for every nonzero count, not only for a count of one. A byte or word rotate whose masked count is zero can still rewrite the flags while leaving the data unchanged. The zero, sign, parity and adjust flags are not touched here and stay with the surrounding flag logic.

A request carries the operand, a raw count byte, an operation code, a size code and the incoming CF and OF. A registered output stage holds the result together with the new flags and an update strobe. The strobe tells the flag file whether CF and OF were rewritten. Input and output each use a valid/ready pair, and a new request can be accepted in every cycle in which the output is drained.

Top module: `rot_flag_unit`

## Requirements
- R1: Operation code 0 rotates left. The count is the low five count bits masked to 3 bits for bytes (size 0) and 4 bits for words (size 1), and used whole for dwords (size 2). On an update, CF is result bit 0 and OF is result bit 0 XOR the result MSB.
- R2: Operation code 1 rotates right with the same count masking as R1. On every update, CF is the result MSB and OF is the result MSB XOR the bit just below it.
- R3: Operation code 2 rotates the (width+1)-bit value {CF, operand} right. The count is the low five count bits modulo 9 for bytes, modulo 17 for words, and unchanged for dwords. For a nonzero count n, CF is operand bit n-1 and OF is the XOR of the two top result bits.
- R4: In some cases the masked rotate count is zero but the flags are still rewritten with the R1/R2 formulas applied to the unchanged operand, and the strobe is 1. For a byte left rotate this happens when count bit 3 or bit 4 is set. For a byte right rotate it happens when count bit 4 is set. For a word rotate in either direction it happens when count bit 4 is set.
- R5: In every other zero-count case, and for operation code 3, the result equals the operand, CF and OF equal the inputs, and the update strobe is 0.
- R6: Count bits above bit 4 have no effect on result, flags or strobe.
- R7: Size code 3 behaves as size 2. Result bits above the selected width are 0.
- R8: in_ready is high when the output register is empty or is being drained. An accepted request appears on the outputs with out_valid in the next cycle. Outputs stay stable while out_valid is high and out_ready is low.
- R9: During reset out_valid is 0, out_result is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_operand | input | DATA_W | Operand; bits above the selected width are ignored |
| in_count | input | CNT_W | Raw rotate count |
| in_op | input | 2 | 0 left, 1 right, 2 right through carry, 3 pass |
| in_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| in_cf | input | 1 | Incoming carry flag |
| in_of | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | DATA_W | Rotated result, zero-extended |
| out_cf | output | 1 | New carry flag |
| out_of | output | 1 | New overflow flag |
| out_flags_upd | output | 1 | CF and OF were rewritten |

## Verification
A wrong count decode shows at the ports one cycle after acceptance. The result is misrotated, or the update strobe and flags differ on exactly the boundary counts (8, 16, 9, 17 and their aliases above bit 4). The bench therefore sweeps all low-five-bit counts for every size and operation, once with clean and once with noisy upper count bits. A corrupted output register or a wrong ready term shows as a missing, extra or changed result within a cycle while back-pressure is applied, and the reference queue compares the outputs on every clock.

// File: rtl/rot_pkg.sv
package rot_pkg;

   typedef enum logic [1:0] {
      ROT_OP_LEFT  = 2'd0,
      ROT_OP_RIGHT = 2'd1,
      ROT_OP_RCR   = 2'd2,
      ROT_OP_PASS  = 2'd3
   } rot_op_e;

   typedef enum logic [1:0] {
      ROT_SZ_8  = 2'd0,
      ROT_SZ_16 = 2'd1,
      ROT_SZ_32 = 2'd2,
      ROT_SZ_32B = 2'd3
   } rot_size_e;

   typedef struct packed {
      logic cf;
      logic of;
      logic upd;
   } rot_flags_t;

   localparam int ROT_CNT_BITS = 5;

endpackage

// File: rtl/rot_lane.sv
module rot_lane
   import rot_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]              opnd,
   input  logic [ROT_CNT_BITS-1:0]   cnt5,
   input  rot_op_e                   op,
   input  logic                      cf_in,
   input  logic                      of_in,
   output logic [W-1:0]              res,
   output rot_flags_t                flags
);

   localparam int LOG_W = $clog2(W);

   if (W != 8 && W != 16 && W != 32) begin : g_bad_width
      $error("rot_lane: W must be 8, 16 or 32");
   end

   logic [LOG_W-1:0] rot_n;
   logic [5:0]       rcr_n;
   logic [6:0]       rot_back;
   logic [6:0]       rcr_back;
   logic [W-1:0]     rol_v;
   logic [W-1:0]     ror_v;
   logic [W:0]       rcr_v;
   logic             keep_rol;
   logic             keep_ror;

   // Count decode: masked count for plain rotates, modulo W+1 for carry rotate.
   assign rot_n    = LOG_W'(cnt5);
   assign rcr_n    = 6'({1'b0, cnt5} % 6'(W + 1));
   assign rot_back = 7'(W) - 7'(rot_n);
   assign rcr_back = 7'(W + 1) - 7'(rcr_n);

   assign rol_v = (opnd << rot_n) | (opnd >> rot_back);
   assign ror_v = (opnd >> rot_n) | (opnd << rot_back);
   assign rcr_v = ({cf_in, opnd} >> rcr_n) | ({cf_in, opnd} << rcr_back);

   // Flag-only cases where the masked count is zero.
   if (W == 8) begin : g_keep_byte
      assign keep_rol = (rot_n == '0) && (cnt5[4:3] != 2'b00);
      assign keep_ror = (rot_n == '0) && cnt5[4];
   end else if (W == 16) begin : g_keep_word
      assign keep_rol = (rot_n == '0) && cnt5[4];
      assign keep_ror = (rot_n == '0) && cnt5[4];
   end else begin : g_keep_none
      assign keep_rol = 1'b0;
      assign keep_ror = 1'b0;
   end

   always_comb begin
      res       = opnd;
      flags.cf  = cf_in;
      flags.of  = of_in;
      flags.upd = 1'b0;
      unique case (op)
         ROT_OP_LEFT: begin
            if ((rot_n != '0) || keep_rol) begin
               res       = rol_v;
               flags.cf  = rol_v[0];
               flags.of  = rol_v[0] ^ rol_v[W-1];
               flags.upd = 1'b1;
            end
         end
         ROT_OP_RIGHT: begin
            if ((rot_n != '0) || keep_ror) begin
               res       = ror_v;
               flags.cf  = ror_v[W-1];
               flags.of  = ror_v[W-1] ^ ror_v[W-2];
               flags.upd = 1'b1;
            end
         end
         ROT_OP_RCR: begin
            if (rcr_n != '0) begin
               res       = rcr_v[W-1:0];
               flags.cf  = rcr_v[W];
               flags.of  = rcr_v[W-1] ^ rcr_v[W-2];
               flags.upd = 1'b1;
            end
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/rot_out_stage.sv
module rot_out_stage
   import rot_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   output logic              load_rdy,
   input  logic [DATA_W-1:0] d_res,
   input  rot_flags_t        d_flags,
   input  logic              take,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_res,
   output rot_flags_t        q_flags
);

   logic load;

   assign load_rdy = !q_valid || take;
   assign load     = load_req && load_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_res   <= '0;
         q_flags <= '0;
      end else begin
         if (load) begin
            q_valid <= 1'b1;
            q_res   <= d_res;
            q_flags <= d_flags;
         end else if (take) begin
            q_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rot_flag_unit.sv
module rot_flag_unit
   import rot_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_operand,
   input  logic [CNT_W-1:0]  in_count,
   input  logic [1:0]        in_op,
   input  logic [1:0]        in_size,
   input  logic              in_cf,
   input  logic              in_of,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_result,
   output logic              out_cf,
   output logic              out_of,
   output logic              out_flags_upd
);

   localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;
   localparam int SEL_W     = $clog2(NUM_LANES);

   if (DATA_W != 32) begin : g_chk_data_w
      $error("rot_flag_unit: DATA_W must be 32");
   end
   if (CNT_W < ROT_CNT_BITS) begin : g_chk_cnt_w
      $error("rot_flag_unit: CNT_W must be at least 5");
   end

   logic [ROT_CNT_BITS-1:0] cnt5;
   rot_op_e                 op_e;
   logic [SEL_W-1:0]        lane_sel;
   logic [DATA_W-1:0]       lane_res [NUM_LANES];
   rot_flags_t              lane_flg [NUM_LANES];
   logic [DATA_W-1:0]       sel_res;
   rot_flags_t              sel_flg;
   rot_flags_t              q_flg;

   assign cnt5 = ROT_CNT_BITS'(in_count);
   assign op_e = rot_op_e'(in_op);

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam int LW = 8 << g;
      logic [LW-1:0] r;
      rot_lane #(.W(LW)) u_lane (
         .opnd  (in_operand[LW-1:0]),
         .cnt5  (cnt5),
         .op    (op_e),
         .cf_in (in_cf),
         .of_in (in_of),
         .res   (r),
         .flags (lane_flg[g])
      );
      assign lane_res[g] = DATA_W'(r);
   end

   assign lane_sel = (in_size >= 2'(NUM_LANES)) ? SEL_W'(NUM_LANES - 1) : SEL_W'(in_size);
   assign sel_res  = lane_res[lane_sel];
   assign sel_flg  = lane_flg[lane_sel];

   rot_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_req (in_valid),
      .load_rdy (in_ready),
      .d_res    (sel_res),
      .d_flags  (sel_flg),
      .take     (out_ready),
      .q_valid  (out_valid),
      .q_res    (out_result),
      .q_flags  (q_flg)
   );

   assign out_cf        = q_flg.cf;
   assign out_of        = q_flg.of;
   assign out_flags_upd = q_flg.upd;

endmodule

// File: rtl/rot_flag_unit_chk.sv
module rot_flag_unit_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_operand,
   input logic [CNT_W-1:0]  in_count,
   input logic [1:0]        in_op,
   input logic [1:0]        in_size,
   input logic              in_cf,
   input logic              in_of,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_result,
   input logic              out_cf,
   input logic              out_of,
   input logic              out_flags_upd
);

   logic acc;
   assign acc = in_valid && in_ready;

   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
         $stable(out_cf) && $stable(out_of) && $stable(out_flags_upd)));

   p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !acc) |=> !out_valid);

   p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op == 2'd3 && in_size[1]) |=> (!out_flags_upd &&
         out_cf == $past(in_cf) && out_of == $past(in_of) &&
         out_result == $past(in_operand)));

   p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_op[1] && in_size[1] && 5'(in_count) == 5'd0) |=>
         (!out_flags_upd && out_cf == $past(in_cf) && out_of == $past(in_of)));

   p_byte_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_size == 2'd0) |=> (out_result[DATA_W-1:8] == '0));

   p_rol_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op == 2'd0 && in_size == 2'd0) |=> (!out_flags_upd ||
         (out_cf == out_result[0] && out_of == (out_result[0] ^ out_result[7]))));

   p_ror_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op == 2'd1 && in_size == 2'd0) |=> (!out_flags_upd ||
         (out_cf == out_result[7] && out_of == (out_result[7] ^ out_result[6]))));

   p_rcr_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_op == 2'd2 && in_size == 2'd1) |=> (!out_flags_upd ||
         out_of == (out_result[15] ^ out_result[14])));

endmodule

bind rot_flag_unit rot_flag_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_rot_flag_unit.sv
module sim_rot_flag_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_operand = '0;
   logic [7:0]  in_count = '0;
   logic [1:0]  in_op = '0;
   logic [1:0]  in_size = '0;
   logic        in_cf = 1'b0;
   logic        in_of = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_result;
   logic        out_cf;
   logic        out_of;
   logic        out_flags_upd;

   always #10 clk = ~clk;

   rot_flag_unit u0 (.*);

   typedef struct {
      logic [31:0] r;
      logic        cf;
      logic        of;
      logic        upd;
      logic [1:0]  size;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   expect_v = 1'b0;
   bit   in_reset = 1'b1;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: one-bit steps repeated n times.
   function automatic exp_t model(input logic [31:0] a, input logic [7:0] c,
                                  input logic [1:0] o, input logic [1:0] s,
                                  input logic ci, input logic oi);
      exp_t        e;
      int          w;
      int          m;
      int          n;
      bit          fo;
      logic [31:0] mask;
      logic [31:0] v;
      logic        cc;
      logic        b;
      w    = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      mask = (w == 32) ? 32'hffff_ffff : ((32'h1 << w) - 32'h1);
      m    = int'(c) % 32;
      v    = a & mask;
      n    = 0;
      fo   = 1'b0;
      case (o)
         2'd0: begin n = m % w; fo = (n == 0) && ((w == 8 && m >= 8) || (w == 16 && m >= 16)); end
         2'd1: begin n = m % w; fo = (n == 0) && (w < 32) && (m >= 16); end
         2'd2: begin n = m % (w + 1); end
         default: n = 0;
      endcase
      e.size = s;
      if (n == 0 && !fo) begin
         e.r = v; e.cf = ci; e.of = oi; e.upd = 1'b0;
         e.tag = (o == 2'd3) ? "R5" : "R5";
      end else begin
         cc = ci;
         for (int i = 0; i < n; i++) begin
            if (o == 2'd0) begin
               b = v[w-1];
               v = ((v << 1) | {31'b0, b}) & mask;
            end else if (o == 2'd1) begin
               b = v[0];
               v = (v >> 1) | ({31'b0, b} << (w - 1));
            end else begin
               b = v[0];
               v = (v >> 1) | ({31'b0, cc} << (w - 1));
               cc = b;
            end
         end
         e.r = v;
         e.upd = 1'b1;
         if (o == 2'd0) begin
            e.cf = v[0]; e.of = v[0] ^ v[w-1];
         end else if (o == 2'd1) begin
            e.cf = v[w-1]; e.of = v[w-1] ^ v[w-2];
         end else begin
            e.cf = cc; e.of = v[w-1] ^ v[w-2];
         end
         if (fo) e.tag = "R4";
         else if (o == 2'd0) e.tag = "R1";
         else if (o == 2'd1) e.tag = "R2";
         else e.tag = "R3";
      end
      if (c[7:5] != 3'b000) e.tag = {e.tag, " R6"};
      if (s == 2'd3) e.tag = {e.tag, " R7"};
      return e;
   endfunction

   // Compared on every clock, away from the active edge.
   always @(negedge clk) begin
      if (in_reset) begin
         chk(out_valid === 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
         chk(in_ready === 1'b1, "R9", "in_ready in reset", 64'(in_ready), 64'd1);
         chk(out_result === 32'd0, "R9", "out_result in reset", 64'(out_result), 64'd0);
      end else if (!done) begin
         chk(out_valid === expect_v, "R8", "out_valid", 64'(out_valid), 64'(expect_v));
         chk(in_ready === (!out_valid || out_ready), "R8", "in_ready",
             64'(in_ready), 64'(!out_valid || out_ready));
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R8", "output without request", 64'(out_result), 64'd0);
            end else begin
               exp_t e;
               e = q[0];
               chk(out_result === e.r, e.tag, "result", 64'(out_result), 64'(e.r));
               chk(out_cf === e.cf, e.tag, "cf", 64'(out_cf), 64'(e.cf));
               chk(out_of === e.of, e.tag, "of", 64'(out_of), 64'(e.of));
               chk(out_flags_upd === e.upd, e.tag, "upd", 64'(out_flags_upd), 64'(e.upd));
               if (e.size < 2'd2)
                  chk((out_result >> (e.size == 2'd0 ? 8 : 16)) == 32'd0, "R7",
                      "upper bits", 64'(out_result), 64'(e.r));
               if (out_ready) void'(q.pop_front());
            end
         end
         expect_v = (in_valid && in_ready) || (out_valid && !out_ready);
         if (in_valid && in_ready)
            q.push_back(model(in_operand, in_count, in_op, in_size, in_cf, in_of));
      end
   end

   // Called at posedge+2; returns at posedge+2 after the request was taken.
   task automatic send(input logic [1:0] o, input logic [1:0] s, input logic [7:0] c,
                       input logic [31:0] a, input logic ci, input logic oi, input logic rdy);
      bit acc;
      in_valid   = 1'b1;
      in_op      = o;
      in_size    = s;
      in_count   = c;
      in_operand = a;
      in_cf      = ci;
      in_of      = oi;
      out_ready  = rdy;
      forever begin
         @(negedge clk);
         acc = in_ready;
         @(posedge clk);
         #2;
         if (acc) break;
         out_ready = 1'b1;
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(negedge clk);
      in_reset = 1'b0;
      @(posedge clk);
      #2;
      // Directed corners (R4, R5, R3, R6)
      send(2'd0, 2'd0, 8'd8,  32'h0000_0081, 1'b0, 1'b1, 1'b1); // R4 byte left, count 8
      send(2'd1, 2'd0, 8'd8,  32'h0000_0081, 1'b1, 1'b0, 1'b1); // R5 byte right, bit 3 only
      send(2'd1, 2'd0, 8'd16, 32'h0000_0040, 1'b0, 1'b0, 1'b1); // R4 byte right, count 16
      send(2'd0, 2'd1, 8'd16, 32'h0000_8000, 1'b0, 1'b0, 1'b1); // R4 word left
      send(2'd2, 2'd0, 8'd9,  32'h0000_00a5, 1'b1, 1'b0, 1'b1); // R3 modulo 9 gives zero
      send(2'd2, 2'd1, 8'd17, 32'h0000_1234, 1'b0, 1'b1, 1'b1); // R3 modulo 17 gives zero
      send(2'd0, 2'd2, 8'd32, 32'h8000_0001, 1'b1, 1'b1, 1'b1); // R6 count 32 is zero
      send(2'd3, 2'd2, 8'd5,  32'hdead_beef, 1'b1, 1'b0, 1'b0); // R5 pass
      // Sweep of every low count, clean then with noisy upper bits and back-pressure
      for (int pass = 0; pass < 2; pass++) begin
         for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
               for (int c = 0; c < 32; c++) begin
                  logic [7:0] cc;
                  cc = 8'(c);
                  if (pass == 1) cc[7:5] = 3'(($urandom % 7) + 1);
                  send(2'(o), 2'(s), cc, $urandom, 1'($urandom), 1'($urandom),
                       (pass == 0) ? 1'b1 : 1'(($urandom % 4) != 0));
               end
            end
         end
      end
      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (4) @(posedge clk);
      chk(q.size() == 0, "R8", "pending results", 64'(q.size()), 64'd0);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
         done = 1'b1;
         finish_run();
      end
   end

endmodule